// File: doc/BRIEF.md
# Receive Descriptor Ownership Lookahead Controller

This block steers a ring of receive descriptors for a network receive path. It remembers whether the host has given it the current and the following descriptor, so that it does not have to poll them again. When a frame has passed filtering, it decides whether the frame can be stored. It allows data to flow into the current buffer. It chains to the following buffer when the frame outgrows the current one. When the frame ends, or an error stops it, the block returns each descriptor to the host with a status write.

Descriptor memory is reached through a small request/grant port. A read returns one bit that says whether the block owns the descriptor. A write always clears that bit. It either changes the ownership bit alone or writes the complete status word. The ring length is 2^`ring_log` entries, with `ring_log` from 0 to 9. When no buffer is available for a frame, the block raises a one-cycle missed pulse and steps a saturating missed-frame counter. The host clears that counter by reading it.

Top module: `rdl_lookahead_ctrl`

## Requirements
- R1: In idle, a `poll_tick` polls the current descriptor when its cached ownership is clear. It otherwise polls the following descriptor when that one is not cached as owned. When both are held, no memory request follows.
- R2: With `ring_log` = 0 only descriptor 0 is ever read. The following descriptor is never polled, and a frame larger than one buffer ends in the buffer-error write.
- R3: When a frame is accepted and the current descriptor is not cached as owned, the first memory access is a read of the current index.
- R4: If that read returns host ownership, `missed` pulses for exactly one cycle and the counter steps once. No memory access happens until `frame_end`.
- R5: Once current ownership is confirmed, the following descriptor is read. `xfer_en` then rises whatever that read returned, and `xfer_en` is only high while the current descriptor is owned.
- R6: A byte that arrives on a full buffer when the following descriptor is not owned causes a full write to the current index. That write has bit 19 (ownership) = 0, bit 17 (buffer error) = 1, bit 16 (overflow) = 1 and the count field = 0. The index advances, and `xfer_en` stays low until `frame_end`.
- R7: A byte that arrives on a full buffer when the following descriptor is owned causes an ownership-only write (`mem_own_only` = 1) to the full buffer. The following descriptor becomes current, the one after it is read and its result kept, and transfer resumes with that byte in the new buffer.
- R8: `frame_end` causes a full write to the buffer in use, with bit 19 = 0, bit 18 (end of packet) = 1 and bits 15:0 = total frame bytes. The cached following entry then becomes the current one.
- R9: Descriptor indices advance by one modulo 2^`ring_log`, and every `mem_idx` lies below the ring length.
- R10: The missed counter saturates at all ones and clears on `miss_rd`. A read in the same cycle as a miss leaves 1.
- R11: A memory request keeps `mem_req`, `mem_we` and `mem_idx` stable until `mem_gnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_log | input | 4 | Log2 of ring length, held while out of reset |
| poll_tick | input | 1 | Routine poll request |
| frame_accept | input | 1 | Frame passed filtering |
| byte_valid | input | 1 | One byte moved to the buffer (honoured only with xfer_en) |
| frame_end | input | 1 | Last byte of the frame has been moved |
| mem_req | output | 1 | Descriptor access request |
| mem_we | output | 1 | Access is a write |
| mem_own_only | output | 1 | Write clears the ownership bit only |
| mem_idx | output | 9 | Descriptor index |
| mem_wdata | output | 20 | Status word for full writes |
| mem_gnt | input | 1 | Access completes this cycle |
| mem_rd_own | input | 1 | Read result: descriptor owned by block |
| xfer_en | output | 1 | Byte transfer permitted |
| missed | output | 1 | One-cycle missed-frame pulse |
| miss_rd | input | 1 | Host read of the counter, clears it |
| miss_cnt | output | 16 | Missed-frame count |

## Verification
On every cycle, assertions check the following. Requests hold stable until granted. Indices stay inside the ring. A single-entry ring never enters a following-descriptor poll. `missed` lasts one cycle. The counter holds at saturation. Byte transfer needs an owned current descriptor, and a tick with both entries held issues no access. The scenarios have to show the rest: the order of reads around acceptance, the exact status words, chaining across several buffers, index wrap, and the error and miss paths. They do this by comparing every memory write with an ownership model that walks the ring.

// File: rtl/rdl_pkg.sv
package rdl_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RPC, ST_RPN, ST_FPC, ST_NPC, ST_RX,
    ST_HAND, ST_LOOK, ST_EOFW, ST_ERRW, ST_DROP
  } rdl_state_e;

  localparam int WORD_W   = 20;
  localparam int OWN_BIT  = 19;
  localparam int EOP_BIT  = 18;
  localparam int BERR_BIT = 17;
  localparam int OFLO_BIT = 16;
  localparam int CNT_W    = 16;
endpackage

// File: rtl/rdl_ring_step.sv
module rdl_ring_step #(
  parameter int IDX_W = 9,
  parameter int LOG_W = 4
) (
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [LOG_W-1:0] ring_log,
  output logic [IDX_W-1:0] nxt_idx,
  output logic             ring_one
);
  logic [IDX_W-1:0] mask;

  always_comb begin
    mask     = ~({IDX_W{1'b1}} << ring_log);
    nxt_idx  = IDX_W'(cur_idx + 1'b1) & mask;
    ring_one = (ring_log == '0);
  end
endmodule

// File: rtl/rdl_sat_ctr.sv
module rdl_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  logic [W-1:0] cnt_q, cnt_n;
  logic         cnt_en;

  always_comb begin
    cnt_n = clr ? '0 : cnt_q;
    if (inc && cnt_n != MAX) cnt_n = cnt_n + 1'b1;
    cnt_en = inc | clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign cnt = cnt_q;

  // R10
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAX && !clr) |=> cnt_q == MAX);
endmodule

// File: rtl/rdl_byte_ctr.sv
module rdl_byte_ctr #(
  parameter int BUF_BYTES = 64,
  parameter int TOT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic             chain,
  output logic             buf_full,
  output logic [TOT_W-1:0] tot
);
  localparam int BW = $clog2(BUF_BYTES + 1);
  logic [BW-1:0]    buf_q, buf_n;
  logic [TOT_W-1:0] tot_q, tot_n;
  logic             cnt_en;

  always_comb begin
    buf_n  = buf_q;
    tot_n  = tot_q;
    cnt_en = clr | inc | chain;
    if (clr) begin
      buf_n = '0;
      tot_n = '0;
    end else if (chain) begin
      buf_n = BW'(1);
      tot_n = tot_q + 1'b1;
    end else if (inc) begin
      buf_n = buf_q + 1'b1;
      tot_n = tot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      tot_q <= '0;
    end else if (cnt_en) begin
      buf_q <= buf_n;
      tot_q <= tot_n;
    end
  end

  assign buf_full = (buf_q == BW'(BUF_BYTES));
  assign tot      = tot_q;

  // R7
  buf_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_q <= BW'(BUF_BYTES));
endmodule

// File: rtl/rdl_lookahead_ctrl.sv
module rdl_lookahead_ctrl
  import rdl_pkg::*;
#(
  parameter int MAX_LOG   = 9,
  parameter int BUF_BYTES = 64,
  parameter int MISS_W    = 16,
  localparam int IDX_W    = MAX_LOG,
  localparam int LOG_W    = $clog2(MAX_LOG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOG_W-1:0]  ring_log,
  input  logic              poll_tick,
  input  logic              frame_accept,
  input  logic              byte_valid,
  input  logic              frame_end,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_own_only,
  output logic [IDX_W-1:0]  mem_idx,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rd_own,
  output logic              xfer_en,
  output logic              missed,
  input  logic              miss_rd,
  output logic [MISS_W-1:0] miss_cnt
);
  rdl_state_e       st_q, st_n;
  logic [IDX_W-1:0] cur_idx_q, cur_idx_n, nxt_idx;
  logic             cur_own_q, cur_own_n, nxt_own_q, nxt_own_n;
  logic             acc_q, acc_n, miss_q, miss_n;
  logic             ring_one, buf_full, cnt_clr, byte_inc, byte_chain;
  logic [CNT_W-1:0] tot;

  rdl_ring_step #(.IDX_W(IDX_W), .LOG_W(LOG_W)) u_step (
    .cur_idx(cur_idx_q), .ring_log(ring_log), .nxt_idx(nxt_idx), .ring_one(ring_one));

  rdl_byte_ctr #(.BUF_BYTES(BUF_BYTES), .TOT_W(CNT_W)) u_bytes (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(byte_inc), .chain(byte_chain),
    .buf_full(buf_full), .tot(tot));

  rdl_sat_ctr #(.W(MISS_W)) u_miss (
    .clk(clk), .rst_n(rst_n), .inc(miss_n), .clr(miss_rd), .cnt(miss_cnt));

  always_comb begin
    st_n = st_q;  cur_idx_n = cur_idx_q;  cur_own_n = cur_own_q;  nxt_own_n = nxt_own_q;
    acc_n = acc_q | frame_accept;  miss_n = 1'b0;
    cnt_clr = 1'b0;  byte_inc = 1'b0;  byte_chain = 1'b0;
    mem_req = 1'b0;  mem_we = 1'b0;  mem_own_only = 1'b0;
    mem_idx = cur_idx_q;  mem_wdata = '0;  xfer_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (acc_q) begin
          acc_n   = frame_accept;
          cnt_clr = 1'b1;
          st_n    = cur_own_q ? (ring_one ? ST_RX : ST_NPC) : ST_FPC;
        end else if (poll_tick) begin
          if (!cur_own_q)                   st_n = ST_RPC;
          else if (!ring_one && !nxt_own_q) st_n = ST_RPN;
        end
      end
      ST_RPC: begin
        mem_req = 1'b1;
        if (mem_gnt) begin cur_own_n = mem_rd_own; st_n = ST_IDLE; end
      end
      ST_RPN: begin
        mem_req = 1'b1;  mem_idx = nxt_idx;
        if (mem_gnt) begin nxt_own_n = mem_rd_own; st_n = ST_IDLE; end
      end
      ST_FPC: begin
        mem_req = 1'b1;
        if (mem_gnt) begin
          if (mem_rd_own) begin
            cur_own_n = 1'b1;
            st_n      = ring_one ? ST_RX : ST_NPC;
          end else begin
            miss_n = 1'b1;
            st_n   = ST_DROP;
          end
        end
      end
      ST_NPC, ST_LOOK: begin
        mem_req = 1'b1;  mem_idx = nxt_idx;
        if (mem_gnt) begin nxt_own_n = mem_rd_own; st_n = ST_RX; end
      end
      ST_RX: begin
        xfer_en = 1'b1;
        if (frame_end) st_n = ST_EOFW;
        else if (byte_valid) begin
          if (!buf_full) byte_inc = 1'b1;
          else if (nxt_own_q && !ring_one) begin
            byte_chain = 1'b1;
            st_n       = ST_HAND;
          end else st_n = ST_ERRW;
        end
      end
      ST_HAND: begin
        mem_req = 1'b1;  mem_we = 1'b1;  mem_own_only = 1'b1;
        if (mem_gnt) begin
          cur_idx_n = nxt_idx;  cur_own_n = 1'b1;  nxt_own_n = 1'b0;
          st_n      = ST_LOOK;
        end
      end
      ST_EOFW: begin
        mem_req = 1'b1;  mem_we = 1'b1;
        mem_wdata[EOP_BIT]     = 1'b1;
        mem_wdata[CNT_W-1:0]   = tot;
        if (mem_gnt) begin
          cur_idx_n = nxt_idx;  cur_own_n = nxt_own_q & ~ring_one;  nxt_own_n = 1'b0;
          st_n      = ST_IDLE;
        end
      end
      ST_ERRW: begin
        mem_req = 1'b1;  mem_we = 1'b1;
        mem_wdata[BERR_BIT] = 1'b1;
        mem_wdata[OFLO_BIT] = 1'b1;
        if (mem_gnt) begin
          cur_idx_n = nxt_idx;  cur_own_n = 1'b0;  nxt_own_n = 1'b0;
          st_n      = ST_DROP;
        end
      end
      ST_DROP: if (frame_end) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cur_idx_q <= '0;
      cur_own_q <= 1'b0;
      nxt_own_q <= 1'b0;
      acc_q     <= 1'b0;
      miss_q    <= 1'b0;
    end else begin
      st_q      <= st_n;
      cur_idx_q <= cur_idx_n;
      cur_own_q <= cur_own_n;
      nxt_own_q <= nxt_own_n;
      acc_q     <= acc_n;
      miss_q    <= miss_n;
    end
  end

  assign missed = miss_q;

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_idx) && $stable(mem_we)));
  // R4
  miss_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    missed |=> !missed);
  // R9
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((mem_idx >> ring_log) == '0));
  // R2
  ring_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ring_one |-> !(st_q inside {ST_RPN, ST_NPC, ST_LOOK}));
  // R5
  xfer_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_en |-> cur_own_q);
  // R1
  poll_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !acc_q && poll_tick && cur_own_q && (nxt_own_q || ring_one))
      |=> !mem_req);
  // R8
  wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);
endmodule

// File: tb/sim_rdl_lookahead_ctrl.sv
module sim_rdl_lookahead_ctrl;
  localparam int PERIOD = 10;
  localparam int B      = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  ring_log = 4'd3;
  logic        poll_tick = 0, frame_accept = 0, byte_valid = 0, frame_end = 0;
  logic        mem_req, mem_we, mem_own_only, mem_gnt = 0, mem_rd_own = 0;
  logic [8:0]  mem_idx;
  logic [19:0] mem_wdata;
  logic        xfer_en, missed, miss_rd = 0;
  logic [3:0]  miss_cnt;

  int nchk = 0, nerr = 0;
  logic own_m [512];
  int rd_cnt = 0;
  int rd_log [16];
  int wr_ptr = 0, exp_n = 0, miss_seen = 0;
  int exp_idx [8];
  bit exp_oo [8];
  logic [19:0] exp_wd [8];
  string exp_tag [8];
  int cur_m = 0, exp_mc = 0;

  rdl_lookahead_ctrl #(.MAX_LOG(9), .BUF_BYTES(B), .MISS_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .ring_log(ring_log), .poll_tick(poll_tick),
    .frame_accept(frame_accept), .byte_valid(byte_valid), .frame_end(frame_end),
    .mem_req(mem_req), .mem_we(mem_we), .mem_own_only(mem_own_only), .mem_idx(mem_idx),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rd_own(mem_rd_own),
    .xfer_en(xfer_en), .missed(missed), .miss_rd(miss_rd), .miss_cnt(miss_cnt));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // descriptor memory model with random grant latency
  always @(negedge clk) begin
    mem_gnt = 1'b0;
    if (rst_n && mem_req && ($urandom % 3 != 0)) begin
      mem_gnt = 1'b1;
      if (!mem_we) begin
        mem_rd_own = own_m[mem_idx];
        if (rd_cnt < 16) rd_log[rd_cnt] = int'(mem_idx);
        rd_cnt++;
      end else begin
        if (wr_ptr < exp_n) begin
          chk(int'(mem_idx) == exp_idx[wr_ptr], exp_tag[wr_ptr], "write index",
              int'(mem_idx), exp_idx[wr_ptr]);
          chk(mem_own_only == exp_oo[wr_ptr], exp_tag[wr_ptr], "write kind",
              int'(mem_own_only), int'(exp_oo[wr_ptr]));
          if (!exp_oo[wr_ptr])
            chk(mem_wdata == exp_wd[wr_ptr], exp_tag[wr_ptr], "status word",
                int'(mem_wdata), int'(exp_wd[wr_ptr]));
        end else chk(1'b0, "R8", "unexpected write", int'(mem_idx), -1);
        own_m[mem_idx] = 1'b0;
        wr_ptr++;
      end
    end
  end

  always @(negedge clk) if (rst_n && missed) miss_seen++;

  task automatic do_reset(input int rl);
    rst_n = 1'b0;  ring_log = 4'(rl);
    for (int k = 0; k < 512; k++) own_m[k] = 1'b0;
    cur_m = 0;  exp_mc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic int nxt_of(input int i);
    return (i + 1) & ((1 << ring_log) - 1);
  endfunction

  task automatic add_exp(input int idx, input bit oo, input logic [19:0] wd, input string tag);
    exp_idx[exp_n] = idx;  exp_oo[exp_n] = oo;  exp_wd[exp_n] = wd;  exp_tag[exp_n] = tag;
    exp_n++;
  endtask

  task automatic run_frame(input int n);
    logic o [512];
    int i, filled, acc, guard, left, settle, exp_miss, new_cur;
    bit good, done;
    for (int k = 0; k < 512; k++) o[k] = own_m[k];
    exp_n = 0;  wr_ptr = 0;  miss_seen = 0;  exp_miss = 0;  good = 0;  acc = 0;
    new_cur = cur_m;
    if (!o[cur_m]) begin
      exp_miss = 1;
      if (exp_mc < 15) exp_mc++;
    end else begin
      i = cur_m;  filled = 0;
      forever begin
        if (n - filled <= B) begin
          add_exp(i, 1'b0, {4'b0100, 16'(n)}, "R8");
          o[i] = 1'b0;  new_cur = nxt_of(i);  good = 1;  acc = n;
          break;
        end
        if (ring_log != 0 && o[nxt_of(i)]) begin
          add_exp(i, 1'b1, 20'h0, "R7");
          o[i] = 1'b0;  i = nxt_of(i);  filled += B;
        end else begin
          add_exp(i, 1'b0, {4'b0011, 16'h0}, "R6");
          o[i] = 1'b0;  new_cur = nxt_of(i);  acc = filled + B + 1;
          break;
        end
      end
    end
    @(negedge clk) frame_accept = 1'b1;
    @(negedge clk) frame_accept = 1'b0;
    left = acc;  guard = 0;  done = 0;  settle = 0;
    while (!done && guard < 3000) begin
      byte_valid = 1'b0;  frame_end = 1'b0;
      guard++;
      if (left > 0) begin
        if (xfer_en && ($urandom % 4 != 0)) begin byte_valid = 1'b1; left--; end
      end else if (good) begin
        if (xfer_en && wr_ptr == exp_n - 1) begin frame_end = 1'b1; done = 1; end
      end else if (wr_ptr == exp_n && miss_seen == exp_miss) begin
        settle++;
        if (settle > 2) begin
          if (!good && exp_miss == 0)
            chk(xfer_en == 1'b0, "R6", "bytes refused after error", int'(xfer_en), 0);
          frame_end = 1'b1;  done = 1;
        end
      end
      @(negedge clk);
    end
    byte_valid = 1'b0;  frame_end = 1'b0;
    guard = 0;
    while (wr_ptr < exp_n && guard < 300) begin guard++; @(negedge clk); end
    repeat (2) @(negedge clk);
    chk(done, "R5", "frame completed", int'(done), 1);
    chk(wr_ptr == exp_n, "R8", "write count", wr_ptr, exp_n);
    chk(miss_seen == exp_miss, "R4", "missed pulses", miss_seen, exp_miss);
    chk(int'(miss_cnt) == exp_mc, "R10", "missed count", int'(miss_cnt), exp_mc);
    cur_m = new_cur;
  endtask

  task automatic tick_and_settle();
    @(negedge clk) poll_tick = 1'b1;
    @(negedge clk) poll_tick = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic read_miss();
    chk(int'(miss_cnt) == exp_mc, "R10", "count before read", int'(miss_cnt), exp_mc);
    miss_rd = 1'b1;
    @(negedge clk) miss_rd = 1'b0;
    chk(miss_cnt == 4'd0, "R10", "count after read", int'(miss_cnt), 0);
    exp_mc = 0;
  endtask

  initial begin
    #(PERIOD * 180000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset(3);
    chk(mem_req == 1'b0, "R11", "reset request", int'(mem_req), 0);
    chk(xfer_en == 1'b0, "R5", "reset xfer", int'(xfer_en), 0);
    chk(missed == 1'b0 && miss_cnt == 4'd0, "R10", "reset counter", int'(miss_cnt), 0);

    // R3 / R5: final poll of current then poll of next, next not owned
    own_m[0] = 1'b1;  rd_cnt = 0;
    run_frame(3);
    chk(rd_cnt == 2, "R3", "reads around acceptance", rd_cnt, 2);
    chk(rd_log[0] == 0, "R3", "first read index", rd_log[0], 0);
    chk(rd_log[1] == 1, "R5", "next poll index", rd_log[1], 1);

    // R4: miss with only the final poll
    rd_cnt = 0;
    run_frame(2);
    chk(rd_cnt == 1, "R4", "accesses on miss", rd_cnt, 1);

    // R1: routine polls stop once both entries held
    own_m[1] = 1'b1;  own_m[2] = 1'b1;  rd_cnt = 0;
    tick_and_settle();
    tick_and_settle();
    repeat (3) tick_and_settle();
    chk(rd_cnt == 2, "R1", "routine polls", rd_cnt, 2);
    chk(rd_log[0] == 1 && rd_log[1] == 2, "R1", "routine poll order", rd_log[1], 2);

    // R7: exactly two buffers, cached current, lookahead to index 3
    rd_cnt = 0;
    run_frame(2 * B);
    chk(rd_cnt == 2 && rd_log[1] == 3, "R7", "lookahead read index", rd_log[1], 3);

    // R6: overrun with next not owned
    own_m[3] = 1'b1;
    run_frame(B + 2);

    // R10: saturation
    for (int k = 0; k < 17; k++) run_frame(1);
    chk(miss_cnt == 4'hF, "R10", "saturated value", int'(miss_cnt), 15);
    read_miss();

    // R2: single entry ring
    do_reset(0);
    own_m[0] = 1'b1;  rd_cnt = 0;
    repeat (3) tick_and_settle();
    chk(rd_cnt == 1, "R2", "polls with one entry", rd_cnt, 1);
    run_frame(B + 1);
    own_m[0] = 1'b1;
    run_frame(B);
    chk(cur_m == 0, "R9", "index wrap on one entry", cur_m, 0);

    // random segments
    foreach (rd_log[k]) rd_log[k] = 0;
    for (int s = 0; s < 3; s++) begin
      do_reset(s == 0 ? 1 : (s == 1 ? 3 : 9));
      for (int f = 0; f < 60; f++) begin
        for (int g = 0; g < 3; g++) begin
          int L;
          L = 1 << ring_log;
          if ($urandom % 3 != 0) own_m[(cur_m + g) % L] = 1'b1;
          if ($urandom % 4 == 0) own_m[$urandom % L] = 1'b1;
        end
        if ($urandom % 3 == 0) tick_and_settle();
        run_frame(1 + int'($urandom % (3 * B + 2)));
        if ($urandom % 6 == 0) read_miss();
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule